// File: doc/BRIEF.md
# Output Clock Divider With Reference Bypass

This block produces one output clock from a fast input clock (the VCO-rate clock) using an integer divider with a ratio from 2 to 20. Until the block is told it has been programmed, it forwards a separate reference clock unchanged, so downstream logic has a usable clock from power-up onward. Once the programmed flag is raised, a glitch-free handover moves the output to the divided clock. The divided output keeps a 50% duty cycle for every ratio. For odd ratios the block extends the high phase by half an input cycle, using the falling edge of the input clock.

A new divide value is taken only at the boundary between two output periods, so ratio changes never produce a short pulse. An active-low power-down input forces the output low at once and drops the output-enable indicator, which stands in for a tri-stated pin. While power-down is active the divider is held idle. It restarts with a full first pulse when power-down is released.

Top module: `clkdiv_bypass`

## Requirements
- R1: While `prog` is low and the handover has settled, `clk_out` equals `clk_ref` at every instant.
- R2: In divided mode with effective ratio N, each output period lasts exactly N `clk_vco` cycles (2N half-cycles).
- R3: In divided mode, the high phase of each output period lasts exactly N half-cycles of `clk_vco`, for even and odd N alike. Each period starts with its high phase on a `clk_vco` rising edge.
- R4: `div_sel` is read as an unsigned 5-bit number. Values 0 and 1 act as ratio 2, values 21 to 31 act as ratio 20, and 2 to 20 act as themselves.
- R5: The ratio is sampled only at the `clk_vco` rising edge that begins a new output period. Every output period is complete, whatever the timing of changes to `div_sel`.
- R6: `out_en` equals `pd_n`. While `pd_n` is low, `clk_out` is low.
- R7: After power-down is released in divided mode, the first output pulse is a full high phase of N half-cycles.
- R8: On the way back to bypass, the divided clock is released only while it is low. The two clock paths are never enabled at the same time, and no divided pulse is truncated.
- R9: While `rst_n` is low, `clk_out` is low and `out_en` follows `pd_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast input clock to be divided |
| clk_ref | input | 1 | Reference clock forwarded while unprogrammed |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 5 | Requested divide ratio, clamped to 2..20 |
| prog | input | 1 | High selects the divided clock, low selects the reference |
| pd_n | input | 1 | Active-low power-down |
| clk_out | output | 1 | Output clock |
| out_en | output | 1 | Output drive enable, low means the pin would float |

## Verification
On every cycle, the assertions check the internal invariants: the divider count stays below the latched ratio, the ratio only moves on a period boundary, the divided clock is low in the last cycle of a period, the two clock-path enables are mutually exclusive, and the divided path is released only while its clock is low. Output gating under power-down is checked on every edge too. Only the bench scenarios can show the waveform itself: the period and high time for each ratio 2 to 20, clamping of out-of-range selections, alignment after a ratio change in mid-period, a full first pulse after power-down, and clean handovers in both directions between bypass and divided mode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int SEL_W     = 5;
    localparam int MIN_RATIO = 2;
    localparam int MAX_RATIO = 20;

    typedef logic [SEL_W-1:0] ratio_t;

    typedef struct packed {
        ratio_t cnt;
        ratio_t ratio;
        logic   hi;
    } div_state_t;
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int STAGES  = 2,
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], d};

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
        end
    endgenerate

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int MIN_R = MIN_RATIO,
    parameter int MAX_R = MAX_RATIO
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run,
    input  ratio_t ratio_req,
    output logic   div_clk,
    output ratio_t cnt_o,
    output ratio_t ratio_o
);
    localparam ratio_t LO = ratio_t'(MIN_R);
    localparam ratio_t HI = ratio_t'(MAX_R);

    div_state_t st_q, st_d;
    ratio_t     lim;
    logic       hi_n_q;

    // Clamp the request and compute the next counter state
    always_comb begin
        if (ratio_req < LO)      lim = LO;
        else if (ratio_req > HI) lim = HI;
        else                     lim = ratio_req;

        st_d = st_q;
        if (!run) begin
            st_d.cnt   = lim - ratio_t'(1);
            st_d.ratio = lim;
            st_d.hi    = 1'b0;
        end else if (st_q.cnt == st_q.ratio - ratio_t'(1)) begin
            st_d.cnt   = '0;
            st_d.ratio = lim;
            st_d.hi    = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + ratio_t'(1);
            st_d.hi    = (st_q.cnt + ratio_t'(1)) < (st_q.ratio >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= LO - ratio_t'(1);
            st_q.ratio <= LO;
            st_q.hi    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // Half-cycle delayed copy stretches the high phase for odd ratios
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) hi_n_q <= 1'b0;
        else        hi_n_q <= st_q.hi;
    end

    assign div_clk = st_q.hi | (st_q.ratio[0] & hi_n_q);
    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
endmodule

// File: rtl/clkdiv_switch.sv
module clkdiv_switch #(
    parameter int SYNC_N = 2
) (
    input  logic clk_ref,
    input  logic clk_vco,
    input  logic rst_n,
    input  logic prog,
    input  logic div_clk,
    output logic ref_en,
    output logic div_en
);
    logic prog_v, prog_r, ref_en_v, div_en_r;
    logic ref_en_q, ref_en_d;
    logic div_en_q, div_en_d;

    clkdiv_sync #(.STAGES(SYNC_N), .FALLING(1'b1)) u_prog_v (
        .clk(clk_vco), .rst_n(rst_n), .d(prog), .q(prog_v));
    clkdiv_sync #(.STAGES(SYNC_N), .FALLING(1'b1)) u_prog_r (
        .clk(clk_ref), .rst_n(rst_n), .d(prog), .q(prog_r));
    clkdiv_sync #(.STAGES(SYNC_N), .FALLING(1'b1)) u_ref_v (
        .clk(clk_vco), .rst_n(rst_n), .d(ref_en_q), .q(ref_en_v));
    clkdiv_sync #(.STAGES(SYNC_N), .FALLING(1'b1)) u_div_r (
        .clk(clk_ref), .rst_n(rst_n), .d(div_en_q), .q(div_en_r));

    always_comb begin
        ref_en_d = !prog_r && !div_en_r;
        if (div_en_q && !prog_v && div_clk) div_en_d = 1'b1;
        else                                div_en_d = prog_v && !ref_en_v;
    end

    always_ff @(negedge clk_ref or negedge rst_n) begin
        if (!rst_n) ref_en_q <= 1'b0;
        else        ref_en_q <= ref_en_d;
    end

    always_ff @(negedge clk_vco or negedge rst_n) begin
        if (!rst_n) div_en_q <= 1'b0;
        else        div_en_q <= div_en_d;
    end

    assign ref_en = ref_en_q;
    assign div_en = div_en_q;
endmodule

// File: rtl/clkdiv_bypass.sv
module clkdiv_bypass
    import clkdiv_pkg::*;
#(
    parameter int MIN_R  = MIN_RATIO,
    parameter int MAX_R  = MAX_RATIO,
    parameter int SYNC_N = 2
) (
    input  logic             clk_vco,
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             prog,
    input  logic             pd_n,
    output logic             clk_out,
    output logic             out_en
);
    logic   ref_en, div_en, div_clk, pd_v, run;
    ratio_t div_cnt, div_ratio;

    clkdiv_sync #(.STAGES(SYNC_N), .FALLING(1'b0)) u_pd_sync (
        .clk(clk_vco), .rst_n(rst_n), .d(pd_n), .q(pd_v));

    assign run = div_en & pd_v;

    clkdiv_core #(.MIN_R(MIN_R), .MAX_R(MAX_R)) u_core (
        .clk      (clk_vco),
        .rst_n    (rst_n),
        .run      (run),
        .ratio_req(div_sel),
        .div_clk  (div_clk),
        .cnt_o    (div_cnt),
        .ratio_o  (div_ratio)
    );

    clkdiv_switch #(.SYNC_N(SYNC_N)) u_switch (
        .clk_ref(clk_ref),
        .clk_vco(clk_vco),
        .rst_n  (rst_n),
        .prog   (prog),
        .div_clk(div_clk),
        .ref_en (ref_en),
        .div_en (div_en)
    );

    assign clk_out = pd_n & ((clk_ref & ref_en) | (div_clk & div_en));
    assign out_en  = pd_n;
endmodule

// File: rtl/clkdiv_bypass_chk.sv
module clkdiv_bypass_chk #(
    parameter int W = 5
) (
    input logic         clk_vco,
    input logic         rst_n,
    input logic         pd_n,
    input logic         clk_out,
    input logic         out_en,
    input logic         ref_en,
    input logic         div_en,
    input logic         div_clk,
    input logic         run,
    input logic [W-1:0] div_cnt,
    input logic [W-1:0] div_ratio
);
    a_r2_cnt_below_ratio: assert property (@(posedge clk_vco) disable iff (!rst_n)
        run |-> (div_cnt < div_ratio));

    a_r3_low_in_last_cycle: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (run && div_cnt == div_ratio - W'(1)) |-> !div_clk);

    a_r5_ratio_on_boundary: assert property (@(posedge clk_vco) disable iff (!rst_n)
        (run && $past(run) && !$stable(div_ratio)) |-> (div_cnt == '0));

    a_r6_powerdown_gates: assert property (@(posedge clk_vco) disable iff (!rst_n)
        !pd_n |-> (!clk_out && !out_en));

    a_r8_paths_exclusive: assert property (@(posedge clk_vco) disable iff (!rst_n)
        $onehot0({ref_en, div_en}));

    a_r8_release_when_low: assert property (@(negedge clk_vco) disable iff (!rst_n)
        $fell(div_en) |-> !$past(div_clk));
endmodule

bind clkdiv_bypass clkdiv_bypass_chk #(.W(clkdiv_pkg::SEL_W)) u_chk (
    .clk_vco  (clk_vco),
    .rst_n    (rst_n),
    .pd_n     (pd_n),
    .clk_out  (clk_out),
    .out_en   (out_en),
    .ref_en   (ref_en),
    .div_en   (div_en),
    .div_clk  (div_clk),
    .run      (run),
    .div_cnt  (div_cnt),
    .div_ratio(div_ratio)
);

// File: tb/tb_clkdiv_bypass.sv
`timescale 1ns/1ps
module tb_clkdiv_bypass;
    localparam int M_IDLE = 0;
    localparam int M_BYP  = 1;
    localparam int M_DIV  = 2;
    localparam int M_PD   = 3;

    logic       clk_vco = 1'b0;
    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [4:0] div_sel = 5'd2;
    logic       prog    = 1'b0;
    logic       pd_n    = 1'b1;
    logic       clk_out, out_en;

    clkdiv_bypass dut (
        .clk_vco(clk_vco), .clk_ref(clk_ref), .rst_n(rst_n), .div_sel(div_sel),
        .prog(prog), .pd_n(pd_n), .clk_out(clk_out), .out_en(out_en));

    always #2.5 clk_vco = ~clk_vco;
    always #7   clk_ref = ~clk_ref;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    int mode = M_IDLE;
    int sel_at_edge = 2;
    bit locked = 0;
    int ph = 0, n_cur = 2, wait_cnt = 0;
    bit prev_o = 0;
    int sidx = 0, rises = 0, last_rise = 0, period_len = 0, hi_len = 0, hi_cnt = 0;
    bit watch = 0;
    int watch_n = 0, hrun = 0;

    function automatic int clampb(int s);
        if (s < 2) return 2;
        if (s > 20) return 20;
        return s;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_sample(bit is_pos);
        bit o;
        o = clk_out;
        sidx++;
        if (o && !prev_o) begin
            rises++;
            period_len = sidx - last_rise;
            hi_len = hi_cnt;
            hi_cnt = 1;
            last_rise = sidx;
        end else if (o) begin
            hi_cnt++;
        end
        if (!o && prev_o && watch)  // R8: no truncated divided pulse during handover
            chk(hrun <= 3 || hrun == watch_n, "R8", hrun, watch_n);
        if (o) hrun++; else hrun = 0;
        case (mode)
            M_BYP: begin
                chk(o == clk_ref, "R1", o, clk_ref);
                chk(out_en == 1'b1, "R6", out_en, 1);
            end
            M_PD: begin
                chk(o == 1'b0, "R6", o, 0);
                chk(out_en == 1'b0, "R6", out_en, 0);
            end
            M_DIV: begin
                if (!locked) begin
                    if (o && !prev_o) begin
                        chk(is_pos, "R3", is_pos, 1);
                        locked = 1;
                        ph = 0;
                        n_cur = clampb(sel_at_edge);
                        wait_cnt = 0;
                    end else begin
                        wait_cnt++;
                        if (wait_cnt == 400) chk(0, "R7", 0, 1);
                    end
                end else begin
                    ph++;
                    if (ph == 2 * n_cur) begin
                        ph = 0;
                        n_cur = clampb(sel_at_edge);
                    end
                    chk(o == (ph < n_cur), "R5", o, int'(ph < n_cur));
                end
            end
            default: ;
        endcase
        prev_o = o;
    endtask

    always @(posedge clk_vco) begin
        sel_at_edge = int'(div_sel);
        #1.25;
        do_sample(1'b1);
    end

    always @(negedge clk_vco) begin
        #1.25;
        do_sample(1'b0);
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    always @(posedge clk_vco) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(posedge clk_vco);
        #1;
    endtask

    task automatic measure(int sel, int expn, string req);
        int r0;
        cycles(1);
        div_sel = 5'(sel);
        r0 = rises;
        wait (rises >= r0 + 3);
        chk(period_len == 2 * expn, req, period_len, 2 * expn);
        chk(hi_len == expn, "R3", hi_len, expn);
    endtask

    initial begin
        cycles(3);
        // R9: reset state
        chk(clk_out == 1'b0, "R9", clk_out, 0);
        chk(out_en == 1'b1, "R9", out_en, 1);
        rst_n = 1'b1;
        cycles(20);
        mode = M_BYP;                    // R1: reference passes through
        cycles(60);

        mode = M_IDLE;
        div_sel = 5'd2;
        prog = 1'b1;
        cycles(40);
        locked = 0; wait_cnt = 0;
        mode = M_DIV;
        for (int n = 2; n <= 20; n++) measure(n, n, "R2");

        // R4: clamping of out-of-range selections
        measure(0, 2, "R4");
        measure(1, 2, "R4");
        measure(21, 20, "R4");
        measure(31, 20, "R4");

        // R5: changes in mid-period, checked by the running model
        measure(3, 3, "R5");
        cycles(1); div_sel = 5'd17;
        cycles(2); div_sel = 5'd5;
        cycles(7); div_sel = 5'd9;
        measure(9, 9, "R5");

        // R6: power-down
        mode = M_IDLE;
        pd_n = 1'b0;
        cycles(2);
        mode = M_PD;
        cycles(30);
        // R7: restart with a full first pulse
        div_sel = 5'd7;
        locked = 0; wait_cnt = 0;
        mode = M_DIV;
        pd_n = 1'b1;
        measure(7, 7, "R7");

        // R8: clean return to bypass
        measure(20, 20, "R2");
        mode = M_IDLE;
        watch_n = 20;
        watch = 1;
        prog = 1'b0;
        cycles(80);
        watch = 0;
        mode = M_BYP;
        cycles(60);
        mode = M_IDLE;

        done = 1;
        summary();
        $finish;
    end
endmodule